// File: doc/BRIEF.md
# Fixed-Point PCA Feature Projector

This block turns one spike waveform into a short feature vector. The waveform arrives as a stream of signed integer samples. For each principal component the block keeps a column of projection weights, an offset and a scale. It accumulates the dot product of the waveform with each column, adds that component's offset, and multiplies the sum by the component's scale. Normalisation is therefore a multiplication by a stored reciprocal and never a division. The scale carries 19 fractional bits, so factors near 1e-5 can still be represented.

All components are computed in parallel, one sample per clock. The rounded and saturated features then leave one per beat, in component order. Weights, offsets and scales are loaded through a write port. That port only accepts a write while no projection is in flight. With 32 samples the whole projection takes 34 cycles, which is 680 ns at 50 MHz.

Top module: `pca_feature_projector`

## Requirements
- R1: Feature c equals round((sum over i of x[i]*W[c][i] + offset[c]) * scale[c] / 2^19). Here x is a signed 16-bit integer and W is signed 16-bit with 13 fractional bits. The offset is signed 32-bit with 13 fractional bits, and the scale is signed 24-bit with 19 fractional bits. The output is a signed 32-bit word with 13 fractional bits.
- R2: The sum is kept at full width. All 32 products at -32768*-32768 with offset 0 and scale 1 (raw) give exactly 65536.
- R3: Rounding is half-up, computed as floor((p + 2^18) / 2^19). A raw product of +2^18 gives 1, -2^18 gives 0, and -3*2^18 gives -1.
- R4: Results above 2^31-1 give 0x7FFFFFFF. Results below -2^31 give 0x80000000.
- R5: inReady is low from the acceptance of sample 32 until the last feature has been taken. A sample offered in that window is not consumed.
- R6: Features leave in component order 0..3. outLast is high on component 3. While outValid is high and outReady is low, outData and outLast hold. After the beat with outLast, outValid drops.
- R7: outValid is low in the cycle after the last sample is accepted and high in the cycle after that.
- R8: cfgReady is high only when idle, meaning no sample of the current spike has been taken and no feature is pending. A write offered while cfgReady is low has no effect.
- R9: Write map (cfgAddr, 8 bits):
  - Bit 7 = 0 writes weight W[addr[6:5]][addr[4:0]] from cfgWdata[15:0].
  - 0x80+c writes offset[c] from cfgWdata[31:0].
  - 0xC0+c writes scale[c] from cfgWdata[23:0].
- R10: When idle, a write takes precedence over a sample. While cfgWe is high in the idle state, inReady is low.
- R11: Synchronous active-high rst empties the accumulators, the features and the control state, which leaves outValid low, inReady high and cfgReady high. Stored weights, offsets and scales are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Sample valid |
| inReady | output | 1 | Sample accepted this cycle when high with inValid |
| inData | input | 16 | Signed integer waveform sample |
| outValid | output | 1 | Feature valid |
| outReady | input | 1 | Downstream takes the feature |
| outData | output | 32 | Signed feature, 13 fractional bits |
| outLast | output | 1 | Marks the final component of a spike |
| cfgWe | input | 1 | Write request |
| cfgReady | output | 1 | Write is accepted when high with cfgWe |
| cfgAddr | input | 8 | Write address, see R9 |
| cfgWdata | input | 32 | Write data |

## Verification
The bench drives all 32 products to the extreme magnitude. A narrow accumulator would wrap there and return a small or negative value instead of 65536. Exact half-step products expose rounding toward zero or toward even. Extreme inputs at unit scale would wrap instead of clamping if saturation is missing. Further checks cover:
- Random output stalls, where a skid-free design that changes outData under back-pressure would be caught.
- Samples and writes offered during a busy projection, where a leaking sample or write corrupts the next spike.
- A write colliding with a first sample.
- A reset in mid-spike, where a stale partial sum would shift every feature.

// File: rtl/pca_proj_pkg.sv
`timescale 1ns/1ps
package pca_proj_pkg;
  // strobes from sequencing control to the arithmetic datapath
  typedef struct packed {
    logic macEn;    // accumulate the current sample
    logic macFirst; // first sample of a spike: restart the sums
    logic calc;     // finish offset, scale, round and clamp
  } dpCtrl_t;
endpackage

// File: rtl/pca_proj_ctrl.sv
`timescale 1ns/1ps
module pca_proj_ctrl
  import pca_proj_pkg::*;
#(
  parameter int NUM_SAMPLES = 32,
  parameter int NUM_COMP    = 4,
  localparam int CNT_W = $clog2(NUM_SAMPLES),
  localparam int SEL_W = (NUM_COMP > 1) ? $clog2(NUM_COMP) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  output logic             inReady,
  input  logic             cfgWe,
  output logic             cfgReady,
  output logic             outValid,
  input  logic             outReady,
  output logic             outLast,
  output dpCtrl_t          strobe,
  output logic [CNT_W-1:0] sampleIdx,
  output logic [SEL_W-1:0] outSel
);
  typedef enum logic [1:0] {ST_LOAD, ST_CALC, ST_OUT} state_t;

  state_t           state;
  logic [CNT_W-1:0] sampleCnt;
  logic [SEL_W-1:0] selCnt;
  logic             idle, inFire, outFire;

  assign idle     = (state == ST_LOAD) && (sampleCnt == '0);
  assign cfgReady = idle;
  assign inReady  = (state == ST_LOAD) && !(idle && cfgWe);
  assign inFire   = inValid && inReady;
  assign outValid = (state == ST_OUT);
  assign outLast  = (selCnt == SEL_W'(NUM_COMP - 1));
  assign outFire  = outValid && outReady;

  assign strobe.macEn    = inFire;
  assign strobe.macFirst = (sampleCnt == '0);
  assign strobe.calc     = (state == ST_CALC);
  assign sampleIdx       = sampleCnt;
  assign outSel          = selCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_LOAD;
      sampleCnt <= '0;
      selCnt    <= '0;
    end else begin
      unique case (state)
        ST_LOAD: if (inFire) begin
          if (sampleCnt == CNT_W'(NUM_SAMPLES - 1)) begin
            sampleCnt <= '0;
            state     <= ST_CALC;
          end else begin
            sampleCnt <= sampleCnt + 1'b1;
          end
        end
        ST_CALC: begin
          selCnt <= '0;
          state  <= ST_OUT;
        end
        ST_OUT: if (outFire) begin
          if (outLast) state <= ST_LOAD;
          else         selCnt <= selCnt + 1'b1;
        end
        default: state <= ST_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/pca_proj_datapath.sv
`timescale 1ns/1ps
module pca_proj_datapath
  import pca_proj_pkg::*;
#(
  parameter int NUM_SAMPLES = 32,
  parameter int SAMPLE_W    = 16,
  parameter int NUM_COMP    = 4,
  parameter int COEF_W      = 16,
  parameter int COEF_FRAC   = 13,
  parameter int OFF_W       = 32,
  parameter int OFF_FRAC    = 13,
  parameter int SCALE_W     = 24,
  parameter int SCALE_FRAC  = 19,
  parameter int OUT_W       = 32,
  parameter int CFG_W       = 32,
  localparam int CNT_W   = $clog2(NUM_SAMPLES),
  localparam int SEL_W   = (NUM_COMP > 1) ? $clog2(NUM_COMP) : 1,
  localparam int COEF_AW = $clog2(NUM_SAMPLES * NUM_COMP),
  localparam int CFG_AW  = COEF_AW + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  dpCtrl_t                    strobe,
  input  logic [CNT_W-1:0]           sampleIdx,
  input  logic signed [SAMPLE_W-1:0] inData,
  input  logic                       cfgWrite,
  input  logic [CFG_AW-1:0]          cfgAddr,
  input  logic [CFG_W-1:0]           cfgWdata,
  input  logic [SEL_W-1:0]           outSel,
  output logic [OUT_W-1:0]           outData
);
  localparam int PROD_W = SAMPLE_W + COEF_W;
  localparam int ACC_W  = PROD_W + CNT_W;
  localparam int ALIGN  = COEF_FRAC - OFF_FRAC;
  localparam int SUM_W  = ((ACC_W > OFF_W + ALIGN) ? ACC_W : OFF_W + ALIGN) + 1;
  localparam int SCL_W  = SUM_W + SCALE_W;
  localparam logic signed [SCL_W-1:0] HALF    = SCL_W'(1) <<< (SCALE_FRAC - 1);
  localparam logic signed [SCL_W-1:0] OUT_MAX = {{(SCL_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [SCL_W-1:0] OUT_MIN = {{(SCL_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic [NUM_COMP-1:0][OUT_W-1:0] featVec;
  logic selCoef, selOff, selScale;

  assign selCoef  = cfgWrite && !cfgAddr[CFG_AW-1];
  assign selOff   = cfgWrite &&  cfgAddr[CFG_AW-1] && !cfgAddr[CFG_AW-2];
  assign selScale = cfgWrite &&  cfgAddr[CFG_AW-1] &&  cfgAddr[CFG_AW-2];

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
    logic signed [COEF_W-1:0]  coefRow [NUM_SAMPLES];
    logic signed [OFF_W-1:0]   offReg;
    logic signed [SCALE_W-1:0] scaleReg;
    logic signed [PROD_W-1:0]  prod;
    logic signed [ACC_W-1:0]   acc;
    logic signed [SUM_W-1:0]   sumVal;
    logic signed [SCL_W-1:0]   scaled, rounded;
    logic [OUT_W-1:0]          featReg, clamped;

    // parameter store, no reset: survives rst
    always_ff @(posedge clk) begin
      if (selCoef && cfgAddr[COEF_AW-1:CNT_W] == SEL_W'(c))
        coefRow[cfgAddr[CNT_W-1:0]] <= cfgWdata[COEF_W-1:0];
      if (selOff && cfgAddr[SEL_W-1:0] == SEL_W'(c))
        offReg <= cfgWdata[OFF_W-1:0];
      if (selScale && cfgAddr[SEL_W-1:0] == SEL_W'(c))
        scaleReg <= cfgWdata[SCALE_W-1:0];
    end

    assign prod = PROD_W'(inData) * PROD_W'(coefRow[sampleIdx]);

    always_comb begin
      sumVal  = SUM_W'(acc) + (SUM_W'(offReg) <<< ALIGN);
      scaled  = SCL_W'(sumVal) * SCL_W'(scaleReg);
      rounded = (scaled + HALF) >>> SCALE_FRAC;
      if (rounded > OUT_MAX)      clamped = OUT_MAX[OUT_W-1:0];
      else if (rounded < OUT_MIN) clamped = OUT_MIN[OUT_W-1:0];
      else                        clamped = rounded[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        acc     <= '0;
        featReg <= '0;
      end else begin
        if (strobe.macEn)
          acc <= strobe.macFirst ? ACC_W'(prod) : acc + ACC_W'(prod);
        if (strobe.calc)
          featReg <= clamped;
      end
    end

    assign featVec[c] = featReg;
  end

  assign outData = featVec[outSel];
endmodule

// File: rtl/pca_feature_projector.sv
`timescale 1ns/1ps
module pca_feature_projector
  import pca_proj_pkg::*;
#(
  parameter int NUM_SAMPLES = 32,
  parameter int SAMPLE_W    = 16,
  parameter int NUM_COMP    = 4,
  parameter int COEF_W      = 16,
  parameter int COEF_FRAC   = 13,
  parameter int OFF_W       = 32,
  parameter int OFF_FRAC    = 13,
  parameter int SCALE_W     = 24,
  parameter int SCALE_FRAC  = 19,
  parameter int OUT_W       = 32,
  parameter int CFG_W       = 32,
  localparam int CFG_AW = $clog2(NUM_SAMPLES * NUM_COMP) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  output logic                inReady,
  input  logic [SAMPLE_W-1:0] inData,
  output logic                outValid,
  input  logic                outReady,
  output logic [OUT_W-1:0]    outData,
  output logic                outLast,
  input  logic                cfgWe,
  output logic                cfgReady,
  input  logic [CFG_AW-1:0]   cfgAddr,
  input  logic [CFG_W-1:0]    cfgWdata
);
  localparam int CNT_W = $clog2(NUM_SAMPLES);
  localparam int SEL_W = (NUM_COMP > 1) ? $clog2(NUM_COMP) : 1;

  dpCtrl_t          strobe;
  logic [CNT_W-1:0] sampleIdx;
  logic [SEL_W-1:0] outSel;
  logic             cfgWrite;

  assign cfgWrite = cfgWe && cfgReady;

  pca_proj_ctrl #(.NUM_SAMPLES(NUM_SAMPLES), .NUM_COMP(NUM_COMP)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .cfgWe(cfgWe), .cfgReady(cfgReady), .outValid(outValid),
    .outReady(outReady), .outLast(outLast), .strobe(strobe),
    .sampleIdx(sampleIdx), .outSel(outSel)
  );

  pca_proj_datapath #(
    .NUM_SAMPLES(NUM_SAMPLES), .SAMPLE_W(SAMPLE_W), .NUM_COMP(NUM_COMP),
    .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC), .OFF_W(OFF_W), .OFF_FRAC(OFF_FRAC),
    .SCALE_W(SCALE_W), .SCALE_FRAC(SCALE_FRAC), .OUT_W(OUT_W), .CFG_W(CFG_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .sampleIdx(sampleIdx),
    .inData($signed(inData)), .cfgWrite(cfgWrite), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .outSel(outSel), .outData(outData)
  );
endmodule

// File: rtl/pca_proj_checker.sv
`timescale 1ns/1ps
module pca_proj_checker #(
  parameter int NUM_SAMPLES = 32,
  parameter int OUT_W       = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [OUT_W-1:0] outData,
  input logic             outLast,
  input logic             cfgWe,
  input logic             cfgReady
);
  localparam int CNT_W = $clog2(NUM_SAMPLES);
  logic [CNT_W-1:0] seenCnt;

  always_ff @(posedge clk) begin
    if (rst) seenCnt <= '0;
    else if (inValid && inReady)
      seenCnt <= (seenCnt == CNT_W'(NUM_SAMPLES - 1)) ? '0 : seenCnt + 1'b1;
  end

  assert_input_blocked_R5: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !inReady);

  assert_hold_output_R6: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

  assert_last_ends_R6: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady && outLast) |=> !outValid);

  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && seenCnt == CNT_W'(NUM_SAMPLES - 1))
      |=> (!outValid && !inReady) ##1 outValid);

  assert_cfg_blocked_R8: assert property (@(posedge clk) disable iff (rst)
    (outValid || seenCnt != '0) |-> !cfgReady);

  assert_cfg_priority_R10: assert property (@(posedge clk) disable iff (rst)
    (cfgWe && cfgReady) |-> !inReady);
endmodule

bind pca_feature_projector pca_proj_checker #(.NUM_SAMPLES(NUM_SAMPLES), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outData(outData),
  .outLast(outLast), .cfgWe(cfgWe), .cfgReady(cfgReady)
);

// File: tb/pca_feature_projector_bench.sv
`timescale 1ns/1ps
module pca_feature_projector_bench;
  localparam int N = 32;
  localparam int C = 4;

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic inValid = 1'b0, outReady = 1'b0, cfgWe = 1'b0;
  logic [15:0] inData = '0;
  logic [7:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic inReady, outValid, outLast, cfgReady;
  logic [31:0] outData;

  pca_feature_projector u_pca_feature_projector (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outLast(outLast),
    .cfgWe(cfgWe), .cfgReady(cfgReady), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata)
  );

  int compared = 0, mismatched = 0, readyMode = 0;
  bit finished = 0;
  longint coefM[C][N];
  longint offM[C];
  longint scaleM[C];
  longint spk[N];
  logic [32:0] expQ[$];
  string tagQ[$];
  string curTag = "R1";
  logic [15:0] lf = 16'hACE1;

  task automatic check(bit ok, string tag, longint act, longint expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] model(int c);
    longint s = 0, p, r;
    for (int i = 0; i < N; i++) s += spk[i] * coefM[c][i];
    s += offM[c];
    p = s * scaleM[c];
    r = (p + (64'sd1 <<< 18)) >>> 19;
    if (r > 64'sd2147483647) return 32'h7FFFFFFF;
    if (r < -64'sd2147483648) return 32'h80000000;
    return r[31:0];
  endfunction

  task automatic cfgWrite(logic [7:0] a, logic [31:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    do @(negedge clk); while (!cfgReady);
    @(posedge clk); #1;
    cfgWe = 1'b0;
  endtask

  task automatic setCoef(int c, int i, longint v);
    cfgWrite({1'b0, 2'(c), 5'(i)}, 32'(v));
    coefM[c][i] = v;
  endtask
  task automatic setOff(int c, longint v);
    cfgWrite(8'h80 | 8'(c), 32'(v));
    offM[c] = v;
  endtask
  task automatic setScale(int c, longint v);
    cfgWrite(8'hC0 | 8'(c), 32'(v));
    scaleM[c] = v;
  endtask

  task automatic drive(int cnt);
    for (int i = 0; i < cnt; i++) begin
      inValid = 1'b1; inData = 16'(spk[i]);
      do @(negedge clk); while (!inReady);
      @(posedge clk); #1;
    end
    inValid = 1'b0;
  endtask

  task automatic sendSpike(string tag);
    for (int c = 0; c < C; c++) begin
      expQ.push_back({c == C - 1, model(c)});
      tagQ.push_back(tag);
    end
    drive(N);
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    @(posedge clk); #1;
  endtask

  function automatic longint nextRand();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return longint'($signed(lf));
  endfunction

  // output ready pattern: 0 always, 1 pseudo random, 2 never
  initial forever begin
    @(posedge clk); #1;
    outReady = (readyMode == 0) ? 1'b1 : (readyMode == 1) ? nextRand()[3] : 1'b0;
  end

  // monitor / scoreboard
  initial begin
    bit holdPend = 0;
    logic [31:0] holdData;
    logic holdLast;
    logic [32:0] e;
    string t;
    forever begin
      @(negedge clk);
      if (holdPend && !rst)
        check(outValid && outData == holdData && outLast == holdLast,
              "R6 held output", longint'($signed(outData)), longint'($signed(holdData)));
      holdPend = outValid && !outReady;
      holdData = outData; holdLast = outLast;
      if (outValid && outReady) begin
        if (expQ.size() == 0) check(0, "R1 unexpected feature", longint'($signed(outData)), 0);
        else begin
          e = expQ.pop_front(); t = tagQ.pop_front();
          check(outData == e[31:0] && outLast == e[32], t,
                longint'($signed(outData)), longint'($signed(e[31:0])));
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!outValid, "R11 reset outValid", outValid, 0);
    check(inReady,   "R11 reset inReady", inReady, 1);
    check(cfgReady,  "R11 reset cfgReady", cfgReady, 1);
    @(posedge clk); #1; rst = 1'b0;

    // general coefficient set (R1, R9)
    for (int c = 0; c < C; c++)
      for (int i = 0; i < N; i++) setCoef(c, i, ((c * 37 + i * 11) % 61 - 30) * 97);
    setOff(0, -12345); setOff(1, 0); setOff(2, 12345); setOff(3, 24690);
    setScale(0, 262144); setScale(1, 5); setScale(2, 700000); setScale(3, 131071);

    for (int i = 0; i < N; i++) spk[i] = i * 1000 - 16000;
    sendSpike("R1 ramp");
    for (int i = 0; i < N; i++) spk[i] = (i % 2) ? 32767 : -32768;
    sendSpike("R9 alternating");
    for (int i = 0; i < N; i++) spk[i] = nextRand();
    sendSpike("R1 random");
    drain();

    // back-pressure (R6)
    readyMode = 1;
    for (int i = 0; i < N; i++) spk[i] = nextRand();
    sendSpike("R6 stalled");
    drain();
    readyMode = 0;
    @(posedge clk); #1;

    // latency (R7)
    for (int i = 0; i < N; i++) spk[i] = nextRand() >>> 3;
    sendSpike("R7 data");
    @(negedge clk); check(!outValid, "R7 calc cycle", outValid, 0);
    @(negedge clk); check(outValid,  "R7 first feature", outValid, 1);
    drain();

    // busy window: sample and write offered while features pend (R5, R8)
    readyMode = 2;
    @(posedge clk); #1;
    for (int i = 0; i < N; i++) spk[i] = nextRand();
    sendSpike("R5 before block");
    repeat (3) @(negedge clk);
    @(posedge clk); #1;
    inValid = 1'b1; inData = 16'd123;
    cfgWe = 1'b1; cfgAddr = 8'h00; cfgWdata = 32'h1234;
    @(negedge clk);
    check(!inReady,  "R5 inReady busy", inReady, 0);
    check(!cfgReady, "R8 cfgReady busy", cfgReady, 0);
    @(posedge clk); #1;
    @(posedge clk); #1;
    inValid = 1'b0; cfgWe = 1'b0;
    readyMode = 0;
    drain();
    sendSpike("R8 write ignored");
    drain();

    // write beats sample when idle (R10)
    inValid = 1'b1; inData = 16'd77;
    cfgWe = 1'b1; cfgAddr = 8'h80; cfgWdata = 32'(offM[0]);
    @(negedge clk);
    check(!inReady, "R10 inReady during write", inReady, 0);
    @(posedge clk); #1;
    cfgWe = 1'b0; inValid = 1'b0;
    @(negedge clk);
    check(inReady, "R10 inReady after write", inReady, 1);
    @(posedge clk); #1;
    sendSpike("R10 no stray sample");
    drain();

    // reset mid-spike (R11)
    for (int i = 0; i < N; i++) spk[i] = nextRand();
    drive(10);
    rst = 1'b1;
    @(posedge clk); #1; @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check(cfgReady, "R11 idle after reset", cfgReady, 1);
    @(posedge clk); #1;
    sendSpike("R11 retained coefficients");
    drain();

    // rounding (R3)
    for (int c = 0; c < C; c++) begin
      for (int i = 0; i < N; i++) setCoef(c, i, 0);
      setOff(c, 0); setScale(c, 262144);
    end
    setCoef(0, 0, 1); setCoef(1, 0, -1); setCoef(2, 0, 3); setOff(3, 1);
    for (int i = 0; i < N; i++) spk[i] = nextRand();
    spk[0] = 1;
    check(model(0) == 1 && model(1) == 0 && model(2) == 2, "R3 hand values",
          longint'($signed(model(1))), 0);
    sendSpike("R3 half up positive");
    spk[0] = -1;
    check(model(0) == 0 && model(2) == 32'hFFFFFFFF, "R3 hand values neg",
          longint'($signed(model(2))), -1);
    sendSpike("R3 half up negative");
    drain();

    // full-width sum (R2) and saturation (R4)
    for (int c = 0; c < C; c++) begin
      for (int i = 0; i < N; i++) setCoef(c, i, -32768);
      setOff(c, 0); setScale(c, 1);
    end
    for (int i = 0; i < N; i++) spk[i] = -32768;
    check(model(0) == 32'd65536, "R2 hand value", longint'(model(0)), 65536);
    sendSpike("R2 extreme sum");
    drain();
    for (int c = 0; c < C; c++) setScale(c, 524288);
    sendSpike("R4 positive clamp");
    for (int i = 0; i < N; i++) spk[i] = 32767;
    sendSpike("R4 negative clamp");
    drain();
    check(expQ.size() == 0, "R6 all features delivered", expQ.size(), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule